// File: doc/BRIEF.md
# Line Sync and NMI Generator

This block produces the horizontal timing of a small home-computer video chip. It counts CPU clock cycles across each scan line and drives an active-low horizontal sync pulse near the end of every line. While the CPU has the interrupt generator switched on, the same pulse is copied to the CPU's non-maskable interrupt pin. Software uses that interrupt to pace its display code line by line.

Two set/reset latches sit beside the counter. Both are controlled by partially decoded CPU I/O cycles. The first latch enables the interrupt output. The second holds the vertical sync level, which also serves as the cassette output.

An input read from the keyboard port starts vertical sync, but only while interrupts are off. Any output write ends vertical sync. The line counter is frozen at zero for as long as vertical sync is active. A read strobe for the external keyboard/tape buffer is also produced.

Top module: `line_sync_gen`

## Requirements
- R1: The line counter runs 0, 1, … LINE_LEN-1 and then returns to 0, so one line lasts LINE_LEN (default 207) clock cycles.
- R2: `hsync_n` is low while the count is between SYNC_START (default 192) and LINE_LEN-1 inclusive, a pulse 15 cycles wide. Once the counter is free to run from zero, `hsync_n` first goes low 192 rising edges later.
- R3: While `vsync` is high, the counter is held at zero and `hsync_n` stays high.
- R4: `nmi_n` follows `hsync_n` while the interrupt enable is set. Otherwise `nmi_n` stays high.
- R5: An I/O write (`iorq_n`=0, `wr_n`=0) with `addr0`=0 sets the interrupt enable on that clock edge.
- R6: An I/O write with `addr1`=0 and `addr0`=1 clears the interrupt enable.
- R7: An I/O write with both `addr0`=0 and `addr1`=0 sets the interrupt enable, because set takes priority.
- R8: `port_rd_n` is low, combinationally, exactly while an I/O read (`iorq_n`=0, `rd_n`=0) has `addr0`=0.
- R9: That read raises `vsync` on the next edge when the interrupt enable is clear. It leaves `vsync` low when the enable is set.
- R10: Any I/O write, at any address, drops `vsync` on that edge. A write with `addr0`=1 and `addr1`=1 does not change the interrupt enable.
- R11: A synchronous reset (`rst_n`=0) gives counter 0, enable clear and `vsync` low. The outputs are then `hsync_n`=1, `nmi_n`=1 and `vsync`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read, active low |
| wr_n | input | 1 | CPU write, active low |
| addr0 | input | 1 | CPU address bit 0 |
| addr1 | input | 1 | CPU address bit 1 |
| hsync_n | output | 1 | Horizontal sync, active low |
| nmi_n | output | 1 | Non-maskable interrupt to the CPU, active low |
| vsync | output | 1 | Vertical sync / tape-out level, active high |
| port_rd_n | output | 1 | Keyboard/tape port read strobe, active low |

## Verification
The hardest state to reach is a frozen line timer. It needs a port read while the interrupt enable is clear, so the stimulus first switches the enable off with a write. Only then does it issue the read. It also shows that the same read does nothing to `vsync` while the enable is on. After the freeze, a write at an address with both low bits high is used to release it. Because the counter restarts from zero, the bench can predict the exact edge of the next sync pulse. It also confirms that this write left the enable untouched.

// File: rtl/lsg_pkg.sv
// Package: shared request type for the line sync generator.
// Assumes the CPU holds its strobes for at least one clock edge.
package lsg_pkg;
    typedef struct packed {
        logic port_rd;   // I/O read with address bit 0 low
        logic wr_any;    // any I/O write
        logic wr_set;    // I/O write with address bit 0 low
        logic wr_clr;    // I/O write with address bit 1 low
    } io_req_t;
endpackage

// File: rtl/lsg_io_decode.sv
// Module: lsg_io_decode
// Turns raw CPU bus strobes into partially decoded I/O requests.
// Assumes active-low strobes; only address bits 0 and 1 are decoded.
module lsg_io_decode
    import lsg_pkg::*;
(
    input  logic    iorq_n,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    addr0,
    input  logic    addr1,
    output io_req_t req
);
    logic io_rd;
    logic io_wr;

    // Purpose: qualify read/write with the I/O request and decode address bits.
    always_comb begin
        io_rd       = !iorq_n && !rd_n;
        io_wr       = !iorq_n && !wr_n;
        req.port_rd = io_rd && !addr0;
        req.wr_any  = io_wr;
        req.wr_set  = io_wr && !addr0;
        req.wr_clr  = io_wr && !addr1;
    end
endmodule

// File: rtl/lsg_ctrl_latches.sv
// Module: lsg_ctrl_latches
// Holds the interrupt-enable and vertical-sync latches. Both are
// updated synchronously on the edge where a request is seen.
// Set beats clear for the enable; a write beats a read for vsync.
module lsg_ctrl_latches
    import lsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  io_req_t req,
    output logic    nmi_en,
    output logic    vsync
);
    // Purpose: interrupt enable latch with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_en <= 1'b0;
        else if (req.wr_set)
            nmi_en <= 1'b1;
        else if (req.wr_clr)
            nmi_en <= 1'b0;
    end

    // Purpose: vertical sync latch, started by a port read, ended by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vsync <= 1'b0;
        else if (req.wr_any)
            vsync <= 1'b0;
        else if (req.port_rd && !nmi_en)
            vsync <= 1'b1;
    end

    // R5 / R7: a write with bit 0 low always leaves the enable set
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_set |=> nmi_en);

    // R6: a clear-only write leaves the enable clear
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr_clr && !req.wr_set) |=> !nmi_en);

    // R10: any write ends vertical sync
    a_r10_write_ends: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_any |=> !vsync);

    // R9: a port read with the enable clear starts vertical sync
    a_r9_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req.port_rd && !nmi_en && !req.wr_any) |=> vsync);
endmodule

// File: rtl/lsg_line_counter.sv
// Module: lsg_line_counter
// Counts clock cycles per scan line and flags the sync window.
// Assumes SYNC_START < LINE_LEN; the counter is held at zero by hold.
module lsg_line_counter #(
    parameter int LINE_LEN   = 207,
    parameter int SYNC_START = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic in_sync
);
    localparam int CNT_W = $clog2(LINE_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(LINE_LEN - 1);
    localparam logic [CNT_W-1:0] START = CNT_W'(SYNC_START);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance the line position, wrap at line end, freeze under hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Purpose: decode the sync window from the line position.
    always_comb in_sync = (cnt >= START);

    // R1: the count never leaves its line range
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1: a free-running count wraps to zero after the last position
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST && !hold) |=> cnt == '0);

    // R3: hold freezes the count at zero on the next edge
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0 && !in_sync));
endmodule

// File: rtl/line_sync_gen.sv
// Module: line_sync_gen (top)
// Horizontal sync and non-maskable interrupt generator with the
// vertical sync and interrupt-enable control latches.
// Assumes a single clock and a synchronous active-low reset.
module line_sync_gen #(
    parameter int LINE_LEN   = 207,
    parameter int SYNC_START = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iorq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic addr0,
    input  logic addr1,
    output logic hsync_n,
    output logic nmi_n,
    output logic vsync,
    output logic port_rd_n
);
    import lsg_pkg::*;

    io_req_t req;
    logic    nmi_en;
    logic    in_sync;

    lsg_io_decode u_decode (
        .iorq_n (iorq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr0  (addr0),
        .addr1  (addr1),
        .req    (req)
    );

    lsg_ctrl_latches u_latches (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .nmi_en (nmi_en),
        .vsync  (vsync)
    );

    lsg_line_counter #(
        .LINE_LEN   (LINE_LEN),
        .SYNC_START (SYNC_START)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (vsync),
        .in_sync (in_sync)
    );

    // Purpose: drive the active-low outputs from sync, enable and port read.
    always_comb begin
        hsync_n   = !in_sync;
        nmi_n     = !(in_sync && nmi_en);
        port_rd_n = !req.port_rd;
    end

    // R4: an interrupt only appears inside a sync pulse with the enable set
    a_r4_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n |-> (!hsync_n && nmi_en));

    // R3: no sync pulse in the cycle after vertical sync is seen
    a_r3_no_sync_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> hsync_n);
endmodule

// File: tb/test_line_sync_gen.sv
module test_line_sync_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n, iorq_n, rd_n, wr_n, addr0, addr1;
    logic hsync_n, nmi_n, vsync, port_rd_n;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_sync_gen i_line_sync_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr0     (addr0),
        .addr1     (addr1),
        .hsync_n   (hsync_n),
        .nmi_n     (nmi_n),
        .vsync     (vsync),
        .port_rd_n (port_rd_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // advance n rising edges, ending at a falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic io_write(input logic a0, input logic a1);
        iorq_n = 1'b0; wr_n = 1'b0; addr0 = a0; addr1 = a1;
        step(1);
        iorq_n = 1'b1; wr_n = 1'b1; addr0 = 1'b1; addr1 = 1'b1;
    endtask

    task automatic wait_sync();
        for (int i = 0; i < 250; i++) begin
            if (hsync_n == 1'b0) return;
            step(1);
        end
        check("R2 sync never seen", hsync_n, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr0 = 1'b1; addr1 = 1'b1;
        step(3);
        check("R11 hsync_n", hsync_n, 1'b1);
        check("R11 nmi_n", nmi_n, 1'b1);
        check("R11 vsync", vsync, 1'b0);
        check("R11 port_rd_n", port_rd_n, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_line_timing();
        logic low_ok = 1'b1;
        step(191);
        check("R2 before start", hsync_n, 1'b1);
        step(1);
        check("R2 pulse starts at 192", hsync_n, 1'b0);
        check("R4 nmi off during sync", nmi_n, 1'b1);
        for (int i = 0; i < 14; i++) begin
            step(1);
            if (hsync_n !== 1'b0) low_ok = 1'b0;
        end
        check("R2 pulse held 15 cycles", low_ok, 1'b1);
        step(1);
        check("R1 wrap ends pulse", hsync_n, 1'b1);
        step(191);
        check("R1 next line before", hsync_n, 1'b1);
        step(1);
        check("R1 period 207", hsync_n, 1'b0);
    endtask

    task automatic t_nmi_enable();
        io_write(1'b0, 1'b1);
        wait_sync();
        check("R5 nmi follows sync", nmi_n, 1'b0);
        step(20);
        check("R4 nmi released", nmi_n, 1'b1);
        io_write(1'b1, 1'b0);
        wait_sync();
        check("R6 nmi cleared", nmi_n, 1'b1);
        io_write(1'b0, 1'b0);
        wait_sync();
        check("R7 set priority", nmi_n, 1'b0);
    endtask

    task automatic t_read_with_nmi_on();
        iorq_n = 1'b0; rd_n = 1'b0; addr0 = 1'b0;
        #1 check("R8 strobe low", port_rd_n, 1'b0);
        step(1);
        iorq_n = 1'b1; rd_n = 1'b1; addr0 = 1'b1;
        #1 check("R8 strobe released", port_rd_n, 1'b1);
        check("R9 no vsync while enabled", vsync, 1'b0);
        iorq_n = 1'b0; rd_n = 1'b0; addr0 = 1'b1;
        #1 check("R8 bit0 high no strobe", port_rd_n, 1'b1);
        step(1);
        iorq_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_vsync_cycle();
        logic quiet = 1'b1;
        io_write(1'b1, 1'b0);
        iorq_n = 1'b0; rd_n = 1'b0; addr0 = 1'b0;
        step(1);
        iorq_n = 1'b1; rd_n = 1'b1; addr0 = 1'b1;
        check("R9 vsync started", vsync, 1'b1);
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (hsync_n !== 1'b1 || vsync !== 1'b1) quiet = 1'b0;
        end
        check("R3 counter held", quiet, 1'b1);
        io_write(1'b1, 1'b1);
        check("R10 write ends vsync", vsync, 1'b0);
        step(191);
        check("R2 restart before", hsync_n, 1'b1);
        step(1);
        check("R2 restart at 192", hsync_n, 1'b0);
        check("R10 enable unchanged", nmi_n, 1'b1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_line_timing();
        t_nmi_enable();
        t_read_with_nmi_on();
        t_vsync_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule